// File: doc/BRIEF.md
# Pipelined Signed Fractional Divider

This block divides an unsigned vector component by the unsigned length of the same vector, where the component never exceeds the length. It returns the quotient as a signed fixed-point fraction. Each input carries a sign flag for the component. The result is a 16-bit two's complement word: one sign bit followed by 15 fraction bits with weights 2^-1 down to 2^-15. A vector normalizer uses three instances, one for each axis.

The quotient is built by a non-restoring recurrence, one bit per pipeline stage. The first step compares the component against half the length. A component equal to the length therefore yields 0.111...1 and no integer bit is spent. Every later stage either subtracts or adds the divisor step, chosen by the previous quotient bit. The remainder never needs a correction. A final stage applies the sign through two's complement negation. The pipeline accepts one operand pair every clock, and a valid bit travels with each pair. The asynchronous reset is released synchronously inside the block.

Top module: `frac_norm_divider`

## Requirements
- R1: A pair presented with `in_valid` high at a rising edge gives `out_valid` high exactly 16 rising edges later, counting the capturing edge as the first. `out_valid` is low in every cycle that has no matching input.
- R2: For a nonzero length L and a component c with c < L, the magnitude bits `out_value[14:0]` equal floor(c * 2^15 / L). The result is truncated, not rounded.
- R3: A component equal to a nonzero length gives the magnitude 0x7FFF, so a positive result is 16'h7FFF.
- R4: A zero component with a nonzero length gives 16'h0000, whatever the sign flag.
- R5: With `in_neg` high, `out_value` is the 16-bit two's complement negation of the unsigned magnitude: bit 15 is 1 and the word is 2^16 minus the magnitude. The only exception is a zero magnitude, which gives 0.
- R6: A zero length, which only occurs together with a zero component, gives 16'h0000 and no other indication.
- R7: While `rst_n` is low, and until the first result of a pair accepted after reset, `out_valid` stays low.
- R8: Pairs presented on consecutive clocks are each computed independently and come out on consecutive clocks, in input order.
- R9: Data presented while `in_valid` is low is ignored. In the matching output cycle `out_valid` is low and `out_value` keeps the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present in this cycle |
| in_neg | input | 1 | Sign flag of the component, 1 means negative |
| in_comp | input | 15 | Unsigned component magnitude, must not exceed `in_len` |
| in_len | input | 15 | Unsigned vector length, used as the divisor |
| out_valid | output | 1 | Result present in this cycle |
| out_value | output | 16 | Signed result: sign bit and 15 fraction bits |

## Verification
Results leave the pipeline in the same cycle that new operands enter it. In that cycle a bubble in the input stream must leave the held output word alone. The bench provokes both at once. It streams back-to-back pairs, and also runs a stream in which valid pairs alternate with invalid cycles that carry random garbage operands. In every output cycle it judges `out_valid` against the input valid pattern 16 cycles earlier. It compares the word either with a fresh reference quotient or with the last valid result. A second overlap is sign negation together with the full-scale quotient. Negative pairs with a component equal to the length are checked for 16'h8001.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Control information that travels alongside each operand pair.
  typedef struct packed {
    logic vld;
    logic neg;
  } fdiv_tag_t;

endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  // Assert immediately, release after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/fdiv_stage.sv
module fdiv_stage
  import frac_div_pkg::*;
#(
  parameter int unsigned W     = 15,
  parameter bit          FIRST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fdiv_tag_t   tag_i,
  input  logic [W:0]  rem_i,
  input  logic [W-1:0] div_i,
  input  logic [W-1:0] q_i,
  output fdiv_tag_t   tag_o,
  output logic [W:0]  rem_o,
  output logic [W-1:0] div_o,
  output logic [W-1:0] q_o
);

  localparam int unsigned RW = W + 1;

  logic          prev_bit;
  logic [RW-1:0] rem_shl;
  logic [RW-1:0] div_ext;
  logic [RW-1:0] rem_d;
  logic [W-1:0]  q_d;

  // The first stage behaves as if the earlier bit were 1: it forms 2c - L.
  generate
    if (FIRST) begin : g_first
      assign prev_bit = 1'b1;
    end else begin : g_next
      assign prev_bit = q_i[0];
    end
  endgenerate

  // Doubling the remainder is the same as halving the divisor step. The
  // true result always fits RW signed bits, so wraparound is harmless.
  always_comb begin
    rem_shl = {rem_i[RW-2:0], 1'b0};
    div_ext = {1'b0, div_i};
    if (prev_bit) begin
      rem_d = rem_shl - div_ext;
    end else begin
      rem_d = rem_shl + div_ext;
    end
    q_d = {q_i[W-2:0], ~rem_d[RW-1]};
  end

  // Valid bit always advances. Data registers load only with a valid pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_o.vld <= 1'b0;
    end else begin
      tag_o.vld <= tag_i.vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_o.neg <= 1'b0;
      rem_o     <= '0;
      div_o     <= '0;
      q_o       <= '0;
    end else if (tag_i.vld) begin
      tag_o.neg <= tag_i.neg;
      rem_o     <= rem_d;
      div_o     <= div_i;
      q_o       <= q_d;
    end
  end

  // R2: the remainder magnitude never exceeds the divisor.
  assert_rem_bound_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    tag_o.vld |-> (($signed(rem_o) <= $signed({1'b0, div_o})) &&
                   ($signed(rem_o) >= -$signed({1'b0, div_o}))));

  // R2: a stage never receives more quotient bits than the word can hold.
  assert_q_headroom_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    tag_i.vld |-> (q_i[W-1] == 1'b0));

endmodule

// File: rtl/fdiv_out.sv
module fdiv_out
  import frac_div_pkg::*;
#(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fdiv_tag_t    tag_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] div_i,
  input  logic [W:0]   rem_i,
  output logic         vld_o,
  output logic [W:0]   val_o
);

  logic [W-1:0] mag;
  logic [W:0]   val_d;

  // A zero divisor means a zero vector: force the magnitude to 0.
  always_comb begin
    mag = (div_i == '0) ? '0 : q_i;
    if (tag_i.neg) begin
      val_d = ~{1'b0, mag} + 1'b1;
    end else begin
      val_d = {1'b0, mag};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= tag_i.vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o <= '0;
    end else if (tag_i.vld) begin
      val_o <= val_d;
    end
  end

  // R5: a negative word always comes from a negative operand.
  assert_sign_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && val_o[W]) |-> $past(tag_i.neg));

  // R6: a zero divisor yields a zero word.
  assert_zero_div_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && ($past(div_i) == '0)) |-> (val_o == '0));

  // R6: with a zero divisor the recurrence leaves a zero remainder.
  assert_zero_rem_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (tag_i.vld && (div_i == '0)) |-> (rem_i == '0));

  // R3: an all-ones positive quotient comes out as the largest positive word.
  assert_full_scale_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(tag_i.vld && (q_i == '1) && (div_i != '0) && !tag_i.neg)
      |-> (val_o == {1'b0, {W{1'b1}}}));

endmodule

// File: rtl/frac_norm_divider.sv
module frac_norm_divider
  import frac_div_pkg::*;
#(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_neg,
  input  logic [W-1:0] in_comp,
  input  logic [W-1:0] in_len,
  output logic         out_valid,
  output logic [W:0]   out_value
);

  localparam int unsigned LAT = W + 1;
  localparam int unsigned CW  = $clog2(LAT + 1);

  logic rst_ns;

  fdiv_tag_t    tag_c [0:W];
  logic [W:0]   rem_c [0:W];
  logic [W-1:0] div_c [0:W];
  logic [W-1:0] q_c   [0:W];

  fdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Entry point of the chain: the remainder starts as the component.
  assign tag_c[0].vld = in_valid;
  assign tag_c[0].neg = in_neg;
  assign rem_c[0]     = {1'b0, in_comp};
  assign div_c[0]     = in_len;
  assign q_c[0]       = '0;

  generate
    for (genvar s = 1; s <= W; s++) begin : g_stage
      fdiv_stage #(.W(W), .FIRST(s == 1)) u_stage (
        .clk   (clk),
        .rst_n (rst_ns),
        .tag_i (tag_c[s-1]),
        .rem_i (rem_c[s-1]),
        .div_i (div_c[s-1]),
        .q_i   (q_c[s-1]),
        .tag_o (tag_c[s]),
        .rem_o (rem_c[s]),
        .div_o (div_c[s]),
        .q_o   (q_c[s])
      );
    end
  endgenerate

  fdiv_out #(.W(W)) u_out (
    .clk   (clk),
    .rst_n (rst_ns),
    .tag_i (tag_c[W]),
    .q_i   (q_c[W]),
    .div_i (div_c[W]),
    .rem_i (rem_c[W]),
    .vld_o (out_valid),
    .val_o (out_value)
  );

  // Cycle counter since reset release, used only to bound out_valid.
  logic [CW-1:0] since_rst_q;
  logic [CW-1:0] since_rst_d;

  always_comb begin
    since_rst_d = since_rst_q;
    if (since_rst_q < CW'(LAT)) begin
      since_rst_d = since_rst_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      since_rst_q <= '0;
    end else begin
      since_rst_q <= since_rst_d;
    end
  end

  // R7: no result appears before a full pipeline traversal after reset.
  assert_quiet_after_reset_R7 : assert property (@(posedge clk) disable iff (!rst_ns)
    out_valid |-> (since_rst_q >= CW'(LAT)));

endmodule

// File: tb/frac_norm_divider_test.sv
`timescale 1ns/1ps
module frac_norm_divider_test;

  localparam int LAT = 16;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_neg;
  logic [14:0] in_comp;
  logic [14:0] in_len;
  logic        out_valid;
  logic [15:0] out_value;

  int errors = 0;
  int checks = 0;
  logic [15:0] held = 16'h0000;

  int st_c [0:63];
  int st_l [0:63];
  bit st_n [0:63];
  bit st_v [0:63];

  frac_norm_divider uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_neg    (in_neg),
    .in_comp   (in_comp),
    .in_len    (in_len),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] model(int c, int l, bit n);
    longint q;
    if (l == 0) return 16'h0000;
    q = (longint'(c) * 32768) / l;
    if (q > 32767) q = 32767;
    return n ? 16'(-q) : 16'(q);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive entries 0..n-1 back to back. Output k is judged LAT negedges later.
  task automatic run_stream(int n, string req);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int k;
        logic [15:0] e;
        k = c - LAT;
        chk(out_valid == st_v[k], {req, " R1 valid"}, out_valid, st_v[k]);
        if (st_v[k]) begin
          e = model(st_c[k], st_l[k], st_n[k]);
          chk(out_value == e, req, out_value, e);
          held = e;
        end else begin
          chk(out_value == held, {req, " R9 hold"}, out_value, held);
        end
      end
      if (c < n) begin
        in_valid = st_v[c];
        in_comp  = 15'(st_c[c]);
        in_len   = 15'(st_l[c]);
        in_neg   = st_n[c];
      end else begin
        in_valid = 1'b0;
        in_comp  = 15'h5a5a;
        in_len   = 15'h2b2b;
        in_neg   = 1'b1;
      end
    end
  endtask

  task automatic put(int i, int c, int l, bit n, bit v);
    st_c[i] = c; st_l[i] = l; st_n[i] = n; st_v[i] = v;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_neg = 1'b0; in_comp = '0; in_len = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 in reset", out_valid, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 after release", out_valid, 0);
    end
  endtask

  // Boundary values: zero, full scale, zero length, extremes of the range.
  task automatic test_edges();
    put(0, 0, 12345, 1'b0, 1'b1);     // R4
    put(1, 0, 12345, 1'b1, 1'b1);     // R4 with sign set
    put(2, 777, 777, 1'b0, 1'b1);     // R3 -> 7fff
    put(3, 777, 777, 1'b1, 1'b1);     // R3 with R5 -> 8001
    put(4, 0, 0, 1'b0, 1'b1);         // R6
    put(5, 0, 0, 1'b1, 1'b1);         // R6
    put(6, 1, 1, 1'b0, 1'b1);         // R3
    put(7, 32766, 32767, 1'b0, 1'b1); // R2 -> 7ffe
    put(8, 1, 32767, 1'b1, 1'b1);     // R2 R5 smallest nonzero quotient
    put(9, 32767, 32767, 1'b1, 1'b1); // R3 R5
    put(10, 5, 10, 1'b0, 1'b1);       // R2 exact half -> 4000
    put(11, 1, 3, 1'b0, 1'b1);        // R2 truncation -> 2aaa
    run_stream(12, "R2 R3 R4 R5 R6 edges");
  endtask

  task automatic test_random_stream();
    for (int i = 0; i < 40; i++) begin
      int l;
      l = $urandom_range(32767, 1);
      put(i, $urandom_range(l, 0), l, bit'($urandom_range(1, 0)), 1'b1);
    end
    run_stream(40, "R2 R5 R8 stream");
  endtask

  task automatic test_bubbles();
    for (int i = 0; i < 40; i++) begin
      int l;
      l = $urandom_range(32767, 1);
      put(i, $urandom_range(l, 0), l, bit'($urandom_range(1, 0)), bit'(i % 3 != 1));
      if (i % 3 == 1) begin
        st_c[i] = $urandom_range(32767, 0);
        st_l[i] = $urandom_range(32767, 0);
      end
    end
    run_stream(40, "R9 R1 bubbles");
  endtask

  initial begin
    #(200000.0 * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_edges();
    test_random_stream();
    test_bubbles();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule